// File: doc/BRIEF.md
# Dual-Role SPI Serial Port

This block is a byte-wide synchronous serial port that acts as either the clock-driving side or the clock-following side of an SPI link. A 4-bit mode field picks the role, and in the driving role it also picks the bit rate. The port holds a shift register and a separate receive holding register. A byte accepted on the transmit stream starts a full-duplex exchange: while that byte leaves MSB first on `sdo`, a byte arrives on `sdi` into the shift register. When the last bit has been sampled, the received byte is copied into the holding register and offered on the receive stream.

Software sets the mode, the clock idle level and the edge choice while `port_en` is low, and then raises `port_en`. While `port_en` is low, the engine and all status are held in reset, and the settings are copied on every cycle. While `port_en` is high, the copied settings are frozen.

Back-pressure works as follows. A byte is accepted only on a cycle where `tx_valid` and `tx_ready` are both high. During an exchange `tx_ready` is low, and a `tx_valid` seen then is dropped, not held: it only sets the collision flag. On the receive side, `rx_valid` stays high until a cycle with `rx_ready` high. The serial line cannot be stalled, so a byte that completes while the holding register is still full is lost, and the overflow flag records the loss.

Top module: `spi_dual_port`

## Requirements
- R1: While `port_en` is low, `rx_valid`, `overflow`, `wcol`, `tx_ready`, `sck_oe` and `sdo_oe` are all low, and any exchange in progress is abandoned.
- R2: `mode_sel`, `cpol` and `late_sample` are captured only while `port_en` is low. Changing them while `port_en` is high has no effect until the port has been disabled and enabled again.
- R3: Mode codes decode as follows:
  - 0000 to 0011: master. `sck_oe` and `sdo_oe` are high.
  - 0100: slave, with `ss_n` in use.
  - 0101: slave, with `ss_n` ignored (always selected).
  - Every other code: the port stays idle, with `tx_ready`, `sck_oe` and `sdo_oe` low.
  - In both slave codes, `sck_oe` is low.
- R4: A byte accepted on the transmit stream is sent on `sdo` MSB first. At the same time, 8 bits are received on `sdi`, and the first bit received becomes bit 7 of `rx_data`.
- R5: With `late_sample` = 0, `sdo` shows bit 7 before the first SCK edge, `sdi` is sampled on each leading edge (idle to active), and `sdo` changes on trailing edges. With `late_sample` = 1, `sdo` changes on leading edges and `sdi` is sampled on trailing edges.
- R6: The idle level of SCK equals `cpol`. In master mode, `sck_o` rests at `cpol` between bytes.
- R7: In master mode, `mode_sel[1:0]` sets the SCK half period in system clocks: 00 gives 2 (divide by 4), 01 gives 8 (divide by 16), and 10 gives 32 (divide by 64). The reserved code 11 behaves like 10.
- R8: After the eighth bit is sampled, `rx_valid` rises and `xfer_done` is high for exactly one cycle, in the same cycle. A cycle with `rx_valid` and `rx_ready` both high clears `rx_valid`.
- R9: If a byte completes while `rx_valid` is high and not being read, the sticky `overflow` flag sets and `rx_data` keeps the older byte.
- R10: `tx_valid` during an exchange is ignored: `tx_ready` is low, the byte on the wire is unchanged, and the sticky `wcol` flag sets.
- R11: In code 0100, while `ss_n` is high, `sdo_oe` is low and the bit counter is held at zero. A partly received byte is discarded and does not raise `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low holds the engine in reset and opens configuration |
| mode_sel | input | 4 | Role and rate code |
| cpol | input | 1 | SCK idle level |
| late_sample | input | 1 | Edge choice: 0 samples on leading edge, 1 on trailing edge |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Port can start an exchange |
| rx_valid | output | 1 | Holding register full |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| xfer_done | output | 1 | One-cycle pulse at the end of each byte |
| overflow | output | 1 | Sticky: a byte was lost to a full holding register |
| wcol | output | 1 | Sticky: a write was attempted during an exchange |
| sck_i | input | 1 | Serial clock from the peer (slave role) |
| sck_o | output | 1 | Serial clock driven (master role) |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data pin |

## Verification
The exchange is driven with bytes that have asymmetric bit patterns in both directions (A5/3C, 81/7E, 0F/F0, FF/00, and others). A bit-order reversal or an off-by-one shift therefore changes the result, instead of cancelling out. These bytes are run in master mode under all four divider codes and all four combinations of polarity and edge choice. The measured SCK half period separates the divider codes, and the received and peer-captured bytes separate correct edge handling from sampling on the wrong edge. In slave mode, the bench acts as the clock source, both with select in use and with select ignored. It also aborts a byte after three bits, which shows whether the counter really returns to zero on deselect. Separate directed sequences cover an unread byte followed by a second byte (overflow), a write in the middle of a byte (collision), a change of settings while enabled, and an unsupported mode code.

// File: rtl/spi_dual_pkg.sv
`timescale 1ns/1ps
package spi_dual_pkg;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

  typedef struct packed {
    role_e      role;
    logic       ss_used;
    logic [1:0] div_sel;
    logic       cpol;
    logic       late;
  } port_cfg_t;

  // Decode of the 4-bit role/rate code into the working configuration.
  function automatic port_cfg_t decode_cfg(input logic [3:0] code,
                                           input logic cp, input logic lt);
    port_cfg_t c;
    c.cpol    = cp;
    c.late    = lt;
    c.div_sel = code[1:0];
    c.ss_used = 1'b0;
    if (code[3:2] == 2'b00) begin
      c.role = ROLE_MASTER;
    end else if (code[3:1] == 3'b010) begin
      c.role    = ROLE_SLAVE;
      c.ss_used = ~code[0];
    end else begin
      c.role = ROLE_OFF;
    end
    return c;
  endfunction

endpackage

// File: rtl/spi_sck_gen.sv
`timescale 1ns/1ps
module spi_sck_gen #(
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 16,
  parameter int DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick
);
  localparam int HALF_MAX = DIV_SLOW / 2;
  localparam int CW       = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  // Half-period limit per rate code; the reserved code falls back to the slowest rate.
  always_comb begin
    unique case (div_sel)
      2'b00:   limit = CW'(DIV_FAST / 2 - 1);
      2'b01:   limit = CW'(DIV_MID / 2 - 1);
      default: limit = CW'(HALF_MAX - 1);
    endcase
  end

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spi_shift_core.sv
`timescale 1ns/1ps
module spi_shift_core #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              is_master,
  input  logic              ss_used,
  input  logic              cpol,
  input  logic              late,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tick,
  input  logic              sck_i,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              busy,
  output logic              sel_active,
  output logic              sck_o,
  output logic              sdo,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int MSB   = DATA_W - 1;

  logic [SYNC_STAGES-1:0] sck_s, ss_s;
  logic                   sck_prev;
  logic [CNT_W-1:0]       cnt;
  logic                   in_bit, busy_m, sck_q, rbit, sdo_q;
  logic [DATA_W-1:0]      shreg;
  logic                   sck_now, ss_now, sck_chg, slave_sel;
  logic                   lead, trail, last;
  logic [DATA_W-1:0]      rx_next;

  assign sck_now   = sck_s[SYNC_STAGES-1];
  assign ss_now    = ss_s[SYNC_STAGES-1];
  assign sck_chg   = sck_now != sck_prev;
  assign slave_sel = is_master || !ss_used || !ss_now;

  // Leading edge leaves the idle level, trailing edge returns to it.
  assign lead  = is_master ? (busy_m && tick && (sck_q == cpol))
                           : (slave_sel && sck_chg && (sck_now != cpol));
  assign trail = is_master ? (busy_m && tick && (sck_q != cpol))
                           : (slave_sel && sck_chg && (sck_now == cpol));
  assign last  = trail && (cnt == CNT_W'(DATA_W - 1));

  assign rx_next    = {shreg[MSB-1:0], (late ? sdi : rbit)};
  assign rx_byte    = rx_next;
  assign done       = en && last;
  assign busy       = is_master ? busy_m : (in_bit || (cnt != '0));
  assign sel_active = slave_sel;
  assign sck_o      = sck_q;
  assign sdo        = sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0; sck_prev <= 1'b0; ss_s <= '1;
      cnt <= '0; in_bit <= 1'b0; busy_m <= 1'b0; sck_q <= 1'b0;
      shreg <= '0; rbit <= 1'b0; sdo_q <= 1'b0;
    end else if (!en) begin
      sck_s <= {SYNC_STAGES{cpol}}; sck_prev <= cpol; ss_s <= '1;
      cnt <= '0; in_bit <= 1'b0; busy_m <= 1'b0; sck_q <= cpol;
      shreg <= '0; rbit <= 1'b0; sdo_q <= 1'b0;
    end else begin
      sck_s    <= {sck_s[SYNC_STAGES-2:0], sck_i};
      ss_s     <= {ss_s[SYNC_STAGES-2:0], ss_n};
      sck_prev <= sck_now;
      if (start) begin
        shreg  <= tx_byte;
        sdo_q  <= tx_byte[MSB];
        busy_m <= is_master;
      end else if (!slave_sel) begin
        cnt    <= '0;
        in_bit <= 1'b0;
        sdo_q  <= shreg[MSB];
      end else if (lead) begin
        in_bit <= 1'b1;
        if (is_master) sck_q <= ~cpol;
        if (late) sdo_q <= shreg[MSB];
        else      rbit  <= sdi;
      end else if (trail) begin
        in_bit <= 1'b0;
        cnt    <= cnt + 1'b1;
        shreg  <= rx_next;
        if (is_master) sck_q <= cpol;
        if (!late) sdo_q <= shreg[MSB-1];
        if (last) busy_m <= 1'b0;
      end else if (cnt == '0 && !in_bit) begin
        sdo_q <= shreg[MSB];
      end
    end
  end

  // R6: between bytes the driven clock rests at its idle level.
  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (is_master && !busy_m) |-> (sck_q == cpol));

  // R11: deselect empties the bit position.
  assert_desel_clear_R11: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (!slave_sel && !start) |=> (cnt == '0 && !in_bit));

endmodule

// File: rtl/spi_status_buf.sv
`timescale 1ns/1ps
module spi_status_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rd,
  input  logic              collide,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              xfer_done,
  output logic              overflow,
  output logic              wcol
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      rx_valid <= 1'b0; rx_data <= '0; xfer_done <= 1'b0;
      overflow <= 1'b0; wcol <= 1'b0;
    end else begin
      xfer_done <= done;
      if (collide) wcol <= 1'b1;
      if (done) begin
        if (rx_valid && !rd) begin
          overflow <= 1'b1;
        end else begin
          rx_data  <= rx_byte;
          rx_valid <= 1'b1;
        end
      end else if (rd) begin
        rx_valid <= 1'b0;
      end
    end
  end

  // R8: the completion pulse lasts one cycle.
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n || !en)
    xfer_done |=> !xfer_done);

  // R9: an unread byte is kept and the loss is recorded.
  assert_keep_old_R9: assert property (@(posedge clk) disable iff (!rst_n || !en)
    (done && rx_valid && !rd) |=> ($stable(rx_data) && overflow));

  // R10: an attempted write during an exchange is remembered.
  assert_wcol_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n || !en)
    collide |=> wcol);

endmodule

// File: rtl/spi_dual_port.sv
`timescale 1ns/1ps
module spi_dual_port
  import spi_dual_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_FAST    = 4,
  parameter int DIV_MID     = 16,
  parameter int DIV_SLOW    = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic [3:0]        mode_sel,
  input  logic              cpol,
  input  logic              late_sample,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              xfer_done,
  output logic              overflow,
  output logic              wcol,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe
);
  port_cfg_t         cfg_q;
  logic              en_run, is_m, busy, sel_active, tick, start, collide, done;
  logic [DATA_W-1:0] rx_byte;

  // Settings are copied only while the port is disabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= decode_cfg(4'b1111, 1'b0, 1'b0);
    else if (!port_en) cfg_q <= decode_cfg(mode_sel, cpol, late_sample);
  end

  assign en_run   = port_en && (cfg_q.role != ROLE_OFF);
  assign is_m     = cfg_q.role == ROLE_MASTER;
  assign tx_ready = en_run && !busy;
  assign start    = tx_valid && tx_ready;
  assign collide  = tx_valid && en_run && busy;
  assign sck_oe   = en_run && is_m;
  assign sdo_oe   = en_run && sel_active;

  spi_sck_gen #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_gen (
    .clk(clk), .rst_n(rst_n), .run(en_run && is_m && busy),
    .div_sel(cfg_q.div_sel), .tick(tick));

  spi_shift_core #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en_run), .is_master(is_m),
    .ss_used(cfg_q.ss_used), .cpol(cfg_q.cpol), .late(cfg_q.late),
    .start(start), .tx_byte(tx_data), .tick(tick), .sck_i(sck_i),
    .ss_n(ss_n), .sdi(sdi), .busy(busy), .sel_active(sel_active),
    .sck_o(sck_o), .sdo(sdo), .done(done), .rx_byte(rx_byte));

  spi_status_buf #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .en(en_run), .done(done), .rx_byte(rx_byte),
    .rd(rx_ready), .collide(collide), .rx_valid(rx_valid), .rx_data(rx_data),
    .xfer_done(xfer_done), .overflow(overflow), .wcol(wcol));

  // R1: a disabled port holds no status.
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!rx_valid && !overflow && !wcol));

  // R2: settings do not move while enabled.
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && $past(port_en)) |-> $stable(cfg_q));

endmodule

// File: tb/sim_spi_dual_port.sv
`timescale 1ns/1ps
module sim_spi_dual_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0;
  logic [3:0] mode_sel = 4'b0000;
  logic       cpol = 1'b0, late_sample = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       xfer_done, overflow, wcol;
  logic       sck_i = 1'b0, sck_o, sck_oe, ss_n = 1'b1, sdi = 1'b0, sdo, sdo_oe;

  int errors = 0, checks = 0, done_cnt = 0;
  logic cur_cpol = 1'b0, cur_late = 1'b0;
  localparam int HB = 12;

  always #5 clk = ~clk;
  always @(posedge clk) if (xfer_done) done_cnt++;

  spi_dual_port u0 (.*);

  // {mode, cpol, late, tx byte, peer byte}
  localparam logic [21:0] VEC [6] = '{
    {4'b0000, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {4'b0001, 1'b1, 1'b0, 8'h5A, 8'hC3},
    {4'b0010, 1'b0, 1'b1, 8'h81, 8'h7E},
    {4'b0011, 1'b1, 1'b1, 8'hFF, 8'h00},
    {4'b0000, 1'b1, 1'b1, 8'h0F, 8'hF0},
    {4'b0001, 1'b0, 1'b1, 8'h96, 8'h69}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgset(input logic [3:0] m, input logic cp, input logic lt);
    @(negedge clk); port_en = 1'b0; mode_sel = m; cpol = cp; late_sample = lt;
    cur_cpol = cp; cur_late = lt; sck_i = cp;
    repeat (3) @(negedge clk);
    port_en = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); tx_valid = 1'b1; tx_data = b;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!xfer_done) @(negedge clk);
  endtask

  // Bench as slave peer of the driven clock.
  task automatic peer_slave(input logic [7:0] pb, output logic [7:0] got, output int half);
    time tl = 0, tt = 0;
    got = 8'h00;
    if (!cur_late) sdi = pb[7];
    for (int i = 0; i < 8; i++) begin
      @(sck_o); #1; if (i == 0) tl = $time;
      if (!cur_late) got = {got[6:0], sdo}; else sdi = pb[7-i];
      @(sck_o); #1; if (i == 0) tt = $time;
      if (cur_late) got = {got[6:0], sdo}; else if (i < 7) sdi = pb[6-i];
    end
    half = int'((tt - tl) / 10);
  endtask

  // Bench as clock source for the slave role.
  task automatic peer_master(input logic [7:0] mb, input int nbits, output logic [7:0] got);
    got = 8'h00; sck_i = cur_cpol;
    if (!cur_late) sdi = mb[7];
    repeat (HB) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sck_i = ~cur_cpol;
      if (!cur_late) got = {got[6:0], sdo}; else sdi = mb[7-i];
      repeat (HB) @(negedge clk);
      sck_i = cur_cpol;
      if (cur_late) got = {got[6:0], sdo}; else if (i < 7) sdi = mb[6-i];
      repeat (HB) @(negedge clk);
    end
  endtask

  task automatic master_xfer(input logic [7:0] tb, input logic [7:0] pb,
                             output logic [7:0] got, output int half);
    fork
      peer_slave(pb, got, half);
      begin send(tb); wait_done(); end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int half, d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset rx_valid", rx_valid, 0);
    chk("R1 reset sck_oe", sck_oe, 0);
    chk("R1 reset tx_ready", tx_ready, 0);

    // Master exchanges over all rates and edge/polarity settings (R4 R5 R6 R7 R8 R3)
    for (int v = 0; v < 6; v++) begin
      cfgset(VEC[v][21:18], VEC[v][17], VEC[v][16]);
      chk("R3 master sck_oe", sck_oe, 1);
      chk("R6 idle level", sck_o, VEC[v][17]);
      master_xfer(VEC[v][15:8], VEC[v][7:0], got, half);
      chk("R4 rx byte", rx_data, VEC[v][7:0]);
      chk("R5 sent byte seen by peer", got, VEC[v][15:8]);
      chk("R7 half period", half, (VEC[v][19:18] == 2'b00) ? 2 : (VEC[v][19:18] == 2'b01) ? 8 : 32);
      chk("R8 rx_valid after done", rx_valid, 1);
      repeat (4) @(negedge clk);
      chk("R6 idle after byte", sck_o, VEC[v][17]);
      take();
      chk("R8 read clears", rx_valid, 0);
    end

    // R2: settings changed while enabled are ignored
    cfgset(4'b0000, 1'b0, 1'b0);
    @(negedge clk); cpol = 1'b1; mode_sel = 4'b0100; late_sample = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 role kept", sck_oe, 1);
    chk("R2 polarity kept", sck_o, 0);
    master_xfer(8'h6B, 8'hD2, got, half);
    chk("R2 rx with old settings", rx_data, 8'hD2);
    chk("R2 rate kept", half, 2);
    take();

    // R9 overflow
    cfgset(4'b0000, 1'b0, 1'b0);
    master_xfer(8'hAA, 8'h11, got, half);
    master_xfer(8'h55, 8'h22, got, half);
    chk("R9 old byte kept", rx_data, 8'h11);
    chk("R9 overflow set", overflow, 1);
    chk("R9 still full", rx_valid, 1);
    take();

    // R10 write collision
    cfgset(4'b0010, 1'b0, 1'b0);
    fork
      peer_slave(8'h99, got, half);
      begin
        send(8'h3E);
        repeat (40) @(negedge clk);
        chk("R10 tx_ready low mid byte", tx_ready, 0);
        send(8'h00);
        wait_done();
      end
    join
    chk("R10 wcol set", wcol, 1);
    chk("R10 byte unchanged", got, 8'h3E);
    chk("R10 rx intact", rx_data, 8'h99);

    // R1 disable clears status
    @(negedge clk); port_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 rx_valid off", rx_valid, 0);
    chk("R1 wcol off", wcol, 0);
    chk("R1 sck_oe off", sck_oe, 0);
    chk("R1 sdo_oe off", sdo_oe, 0);
    chk("R1 tx_ready off", tx_ready, 0);

    // R3 unsupported code
    cfgset(4'b0110, 1'b0, 1'b0);
    chk("R3 idle tx_ready", tx_ready, 0);
    chk("R3 idle sdo_oe", sdo_oe, 0);
    chk("R3 idle sck_oe", sck_oe, 0);

    // Slave, select used, early sampling
    ss_n = 1'b1;
    cfgset(4'b0100, 1'b0, 1'b0);
    chk("R11 sdo tri-stated", sdo_oe, 0);
    chk("R3 slave sck_oe", sck_oe, 0);
    send(8'hC6);
    @(negedge clk); ss_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 sdo driven when selected", sdo_oe, 1);
    peer_master(8'h3B, 8, got);
    chk("R4 slave rx", rx_data, 8'h3B);
    chk("R5 slave tx early", got, 8'hC6);
    take();
    ss_n = 1'b1;

    // Slave, select used, polarity 1, late sampling, then aborted byte
    cfgset(4'b0100, 1'b1, 1'b1);
    send(8'h71);
    @(negedge clk); ss_n = 1'b0;
    repeat (4) @(negedge clk);
    peer_master(8'hE4, 8, got);
    chk("R4 slave rx late", rx_data, 8'hE4);
    chk("R5 slave tx late", got, 8'h71);
    take();
    d0 = done_cnt;
    peer_master(8'hFF, 3, got);
    @(negedge clk); ss_n = 1'b1;
    repeat (6) @(negedge clk);
    ss_n = 1'b0;
    repeat (4) @(negedge clk);
    peer_master(8'h5C, 8, got);
    chk("R11 partial byte discarded", rx_data, 8'h5C);
    chk("R11 single completion", done_cnt - d0, 1);
    take();
    ss_n = 1'b1;

    // Slave, select ignored
    cfgset(4'b0101, 1'b0, 1'b0);
    chk("R3 select ignored drives sdo", sdo_oe, 1);
    send(8'hA7);
    peer_master(8'h2D, 8, got);
    chk("R3 select ignored rx", rx_data, 8'h2D);
    chk("R3 select ignored tx", got, 8'hA7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule